// File: doc/BRIEF.md
# MSI doorbell frame

This block is a memory-mapped frame that turns message-signalled interrupt writes into interrupt edges. A device or bridge writes a 32-bit word into the frame over a simple write/read bus. When the write is a valid doorbell, the frame raises a one-cycle pulse on one line of its shared-peripheral-interrupt output vector. Line `i` of that vector stands for SPI number `BASE_SPI + i`. Every interrupt leaves the frame as a rising edge, never as a level.

The interrupt number can be chosen in one of four ways, fixed by the `MODE` parameter:

- **Absolute data mode:** the word written to the doorbell register is the SPI number itself.
- **Base-offset data mode:** the word is the SPI number minus `BASE_SPI`.
- **Offset-32 data mode:** the word is the SPI number minus 32.
- **Address-encoded mode:** the frame spans 8 KB. The SPI number comes from the write address and the data word is ignored.

Software finds the assigned range by reading a packed type register and a fixed identification register. In address-encoded mode those two registers read as zero, so the range must come from the parameters.

The range set by the parameters is checked when the design is elaborated. A range that breaks the platform limits leaves the frame silent.

Top module: `msi_doorbell_frame`

## Requirements
- R1: A read of byte offset 0x008 returns the type word. Bits [25:16] hold `BASE_SPI` and bits [9:0] hold `SPI_COUNT`. Bits [31:26] and [15:10] read as zero.
- R2: A read of byte offset 0xFCC returns `IDENT_CODE`. A read of any other offset returns zero. `rdata` holds the read result in the cycle after `rd_en` and is zero in every cycle that does not follow a read.
- R3: In absolute data mode, a write of value N to byte offset 0x040, with N from `BASE_SPI` to `BASE_SPI+SPI_COUNT-1`, drives `spi_pulse[N-BASE_SPI]` high for exactly the one cycle after the write. At most one line is high at any time.
- R4: In base-offset data mode the SPI number is the written value plus `BASE_SPI`. In offset-32 data mode it is the written value plus 32. The sum is formed without wrapping.
- R5: In address-encoded mode, a write whose address has bits [2:0] equal to zero selects SPI number `addr[ADDR_W-1:3] + 32`, whatever the data. A write whose address has nonzero low bits is dropped. Reads of the type and identification offsets return zero in this mode.
- R6: A doorbell write whose SPI number falls outside `BASE_SPI` to `BASE_SPI+SPI_COUNT-1` raises no line.
- R7: If `BASE_SPI` is below 32, or `SPI_COUNT` is zero, or `BASE_SPI+SPI_COUNT` exceeds 1019, the frame raises no line for any write.
- R8: In the data modes, writes to any offset other than 0x040 raise no line and do not change what the type register reads back.
- R9: Doorbell writes in consecutive cycles to different SPIs give separate one-cycle pulses, in the cycles following each write and in write order.
- R10: While `rst_n` is low, `spi_pulse` and `rdata` are zero at every clock edge, even if writes are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address within the frame |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| spi_pulse | output | SPI_COUNT | One-cycle interrupt edges; bit i is SPI `BASE_SPI+i` |

## Verification
A doorbell write and a read of the frame's registers can occur in the same cycle. The bus also accepts a second doorbell in the very next cycle, before the first pulse has ended.

The bench drives a write and a read of the type register together. It then checks that the pulse and the read data each appear one cycle later without disturbing each other.

It also issues back-to-back doorbells to two different SPIs and samples each following cycle. It expects the first line alone, then the second line alone, then silence.

// File: rtl/msi_frame_pkg.sv
// Shared constants, mode encoding and the range rule for the MSI doorbell frame.
package msi_frame_pkg;

    // How a doorbell write names its interrupt
    typedef enum logic [1:0] {
        DATA_ABS      = 2'd0,  // data word is the SPI number
        DATA_SUB_BASE = 2'd1,  // data word is SPI number minus BASE_SPI
        DATA_SUB_32   = 2'd2,  // data word is SPI number minus 32
        ADDR_ENC      = 2'd3   // SPI number taken from the address, data ignored
    } doorbell_mode_e;

    localparam int unsigned LOWEST_SPI  = 32;
    localparam int unsigned HIGHEST_SPI = 1019;

    // Byte offsets inside a data-mode frame
    localparam logic [11:0] OFS_TYPE     = 12'h008;
    localparam logic [11:0] OFS_DOORBELL = 12'h040;
    localparam logic [11:0] OFS_IDENT    = 12'hFCC;

    // Returns 1 when a base/count pair respects the platform SPI limits
    function automatic logic range_valid(int unsigned base, int unsigned count);
        return (base >= LOWEST_SPI) && (count != 0) && (base + count <= HIGHEST_SPI);
    endfunction

endpackage

// File: rtl/msi_reg_read.sv
// Read port of the frame: type word and identification code.
// The read result is registered, so it appears the cycle after rd_en.
// Assumes ADDR_W >= 12. In address-encoded mode every read returns zero.
module msi_reg_read
    import msi_frame_pkg::*;
#(
    parameter int unsigned   ADDR_W     = 13,
    parameter int unsigned   BASE_SPI   = 64,
    parameter int unsigned   SPI_COUNT  = 32,
    parameter logic [31:0]   IDENT_CODE = 32'h0005_A3C1,
    parameter bit            ADDR_ONLY  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [31:0]       rdata
);

    localparam logic [9:0]  BASE_F    = 10'(BASE_SPI);
    localparam logic [9:0]  COUNT_F   = 10'(SPI_COUNT);
    localparam logic [31:0] TYPE_WORD = {6'b0, BASE_F, 6'b0, COUNT_F};

    logic [31:0] decoded;
    logic [31:0] rd_value;

    // Select the word addressed by the read
    always_comb begin
        if (addr == ADDR_W'(OFS_TYPE)) begin
            decoded = TYPE_WORD;
        end else if (addr == ADDR_W'(OFS_IDENT)) begin
            decoded = IDENT_CODE;
        end else begin
            decoded = '0;
        end
        rd_value = ADDR_ONLY ? 32'h0 : decoded;
    end

    // Register the read result; zero when no read was requested
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= rd_en ? rd_value : 32'h0;
        end
    end

endmodule

// File: rtl/msi_doorbell_decode.sv
// Turns a bus write into a target line index and a hit flag.
// The MODE parameter picks how the SPI number is formed.
// Sums are held in 33 bits, so no data value can wrap into range.
// Assumes ADDR_W >= 12 and SPI_COUNT >= 1.
module msi_doorbell_decode
    import msi_frame_pkg::*;
#(
    parameter int unsigned    ADDR_W    = 13,
    parameter int unsigned    BASE_SPI  = 64,
    parameter int unsigned    SPI_COUNT = 32,
    parameter doorbell_mode_e MODE      = DATA_ABS,
    localparam int unsigned   IDX_W     = (SPI_COUNT > 1) ? $clog2(SPI_COUNT) : 1
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);

    localparam logic RANGE_OK = range_valid(BASE_SPI, SPI_COUNT);
    localparam logic [32:0] LO_SPI = 33'(BASE_SPI);
    localparam logic [32:0] HI_SPI = 33'(BASE_SPI) + 33'(SPI_COUNT);

    logic        sel;
    logic [32:0] spi_num;
    logic [32:0] rel;
    logic        in_range;

    // Form the SPI number according to the configured mode
    generate
        if (MODE == ADDR_ENC) begin : g_addr
            assign sel     = wr_en && (addr[2:0] == 3'b000);
            assign spi_num = 33'(addr[ADDR_W-1:3]) + 33'(LOWEST_SPI);
        end else if (MODE == DATA_SUB_BASE) begin : g_sub_base
            assign sel     = wr_en && (addr == ADDR_W'(OFS_DOORBELL));
            assign spi_num = {1'b0, wdata} + LO_SPI;
        end else if (MODE == DATA_SUB_32) begin : g_sub_32
            assign sel     = wr_en && (addr == ADDR_W'(OFS_DOORBELL));
            assign spi_num = {1'b0, wdata} + 33'(LOWEST_SPI);
        end else begin : g_abs
            assign sel     = wr_en && (addr == ADDR_W'(OFS_DOORBELL));
            assign spi_num = {1'b0, wdata};
        end
    endgenerate

    // Range check and index relative to the first assigned SPI
    always_comb begin
        in_range = (spi_num >= LO_SPI) && (spi_num < HI_SPI);
        rel      = spi_num - LO_SPI;
        hit      = sel && in_range && RANGE_OK;
        idx      = rel[IDX_W-1:0];
    end

    logic unused_bits;
    assign unused_bits = ^{rel[32:IDX_W], wdata};

endmodule

// File: rtl/msi_pulse_gen.sv
// Registered one-hot pulse driver.
// A hit raises line idx for the following cycle only.
// Assumes idx < SPI_COUNT whenever fire is high.
module msi_pulse_gen #(
    parameter int unsigned  SPI_COUNT = 32,
    localparam int unsigned IDX_W     = (SPI_COUNT > 1) ? $clog2(SPI_COUNT) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fire,
    input  logic [IDX_W-1:0]     idx,
    output logic [SPI_COUNT-1:0] pulse
);

    logic [SPI_COUNT-1:0] next_pulse;

    // One-hot of the selected line, empty when nothing fires
    always_comb begin
        next_pulse = '0;
        if (fire) begin
            next_pulse[idx] = 1'b1;
        end
    end

    // Every pulse lives for exactly one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= '0;
        end else begin
            pulse <= next_pulse;
        end
    end

endmodule

// File: rtl/msi_doorbell_frame.sv
// MSI doorbell frame top.
// Bus writes that name an SPI in the assigned range become one-cycle
// rising edges on spi_pulse. Reads return the type and identification words.
// Assumes a single-cycle write/read bus with no back-pressure.
module msi_doorbell_frame
    import msi_frame_pkg::*;
#(
    parameter int unsigned    ADDR_W     = 13,
    parameter int unsigned    BASE_SPI   = 64,
    parameter int unsigned    SPI_COUNT  = 32,
    parameter doorbell_mode_e MODE       = DATA_ABS,
    parameter logic [31:0]    IDENT_CODE = 32'h0005_A3C1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [31:0]          wdata,
    output logic [31:0]          rdata,
    output logic [SPI_COUNT-1:0] spi_pulse
);

    localparam int unsigned IDX_W = (SPI_COUNT > 1) ? $clog2(SPI_COUNT) : 1;

    logic             db_hit;
    logic [IDX_W-1:0] db_idx;

    // Decode the write into a target line
    msi_doorbell_decode #(
        .ADDR_W   (ADDR_W),
        .BASE_SPI (BASE_SPI),
        .SPI_COUNT(SPI_COUNT),
        .MODE     (MODE)
    ) u_decode (
        .wr_en(wr_en),
        .addr (addr),
        .wdata(wdata),
        .hit  (db_hit),
        .idx  (db_idx)
    );

    // Drive the edge on the selected line
    msi_pulse_gen #(
        .SPI_COUNT(SPI_COUNT)
    ) u_pulse (
        .clk  (clk),
        .rst_n(rst_n),
        .fire (db_hit),
        .idx  (db_idx),
        .pulse(spi_pulse)
    );

    // Serve the read-only registers
    msi_reg_read #(
        .ADDR_W    (ADDR_W),
        .BASE_SPI  (BASE_SPI),
        .SPI_COUNT (SPI_COUNT),
        .IDENT_CODE(IDENT_CODE),
        .ADDR_ONLY (MODE == ADDR_ENC)
    ) u_read (
        .clk  (clk),
        .rst_n(rst_n),
        .rd_en(rd_en),
        .addr (addr),
        .rdata(rdata)
    );

endmodule

// File: rtl/msi_frame_checker.sv
// Temporal checks on the frame's ports, bound to every instance of the top.
module msi_frame_checker
    import msi_frame_pkg::*;
#(
    parameter int unsigned    ADDR_W    = 13,
    parameter int unsigned    BASE_SPI  = 64,
    parameter int unsigned    SPI_COUNT = 32,
    parameter doorbell_mode_e MODE      = DATA_ABS
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic                 rd_en,
    input logic [ADDR_W-1:0]    addr,
    input logic [31:0]          rdata,
    input logic [SPI_COUNT-1:0] spi_pulse
);

    localparam bit RANGE_OK  = range_valid(BASE_SPI, SPI_COUNT);
    localparam bit DATA_MODE = (MODE != ADDR_ENC);

    // R3: never more than one line high
    a_r3_pulse_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(spi_pulse));

    // R9: any pulse is caused by a write in the cycle before
    a_r9_pulse_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_pulse != '0) |-> $past(wr_en));

    // R7: an invalid range keeps every line low
    a_r7_invalid_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (!RANGE_OK) |-> (spi_pulse == '0));

    // R8: in data modes only the doorbell offset can raise a line
    a_r8_other_offset_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (DATA_MODE && ($past(addr) != ADDR_W'(OFS_DOORBELL))) |-> (spi_pulse == '0));

    // R5: misaligned address-encoded writes raise nothing
    a_r5_misaligned_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (!DATA_MODE && ($past(addr[2:0]) != 3'b000)) |-> (spi_pulse == '0));

    // R2: read data is zero when no read preceded
    a_r2_rdata_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rd_en)) |-> (rdata == 32'h0));

endmodule

bind msi_doorbell_frame msi_frame_checker #(
    .ADDR_W   (ADDR_W),
    .BASE_SPI (BASE_SPI),
    .SPI_COUNT(SPI_COUNT),
    .MODE     (MODE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .rdata    (rdata),
    .spi_pulse(spi_pulse)
);

// File: tb/tb_msi_doorbell_frame.sv
// Bench: five frame instances share one bus.
// A vector table is walked first, then directed tests for reset, reads,
// overlap and back-to-back doorbells.
module tb_msi_doorbell_frame;
    import msi_frame_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 13;
    localparam logic [31:0] ID = 32'h0005_A3C1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;

    logic [31:0] p_abs, p_ob, p_o32, p_ao, p_bad;
    logic [31:0] rd_abs, rd_ob, rd_o32, rd_ao, rd_bad;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_doorbell_frame #(.ADDR_W(AW), .BASE_SPI(64), .SPI_COUNT(32), .MODE(DATA_ABS), .IDENT_CODE(ID))
        dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
             .wdata(wdata), .rdata(rd_abs), .spi_pulse(p_abs));
    msi_doorbell_frame #(.ADDR_W(AW), .BASE_SPI(64), .SPI_COUNT(32), .MODE(DATA_SUB_BASE), .IDENT_CODE(ID))
        dut_ob (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
                .wdata(wdata), .rdata(rd_ob), .spi_pulse(p_ob));
    msi_doorbell_frame #(.ADDR_W(AW), .BASE_SPI(64), .SPI_COUNT(32), .MODE(DATA_SUB_32), .IDENT_CODE(ID))
        dut_o32 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
                 .wdata(wdata), .rdata(rd_o32), .spi_pulse(p_o32));
    msi_doorbell_frame #(.ADDR_W(AW), .BASE_SPI(64), .SPI_COUNT(32), .MODE(ADDR_ENC), .IDENT_CODE(ID))
        dut_ao (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
                .wdata(wdata), .rdata(rd_ao), .spi_pulse(p_ao));
    msi_doorbell_frame #(.ADDR_W(AW), .BASE_SPI(16), .SPI_COUNT(32), .MODE(DATA_ABS), .IDENT_CODE(ID))
        dut_bad (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
                 .wdata(wdata), .rdata(rd_bad), .spi_pulse(p_bad));

    typedef struct packed {
        logic [AW-1:0] a;
        logic [31:0]   d;
        logic [31:0]   e_abs;
        logic [31:0]   e_ob;
        logic [31:0]   e_o32;
        logic [31:0]   e_ao;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{13'h040, 32'd64,         32'h0000_0001, 32'h0,         32'h0,         32'h0},         // R3 lowest
        '{13'h040, 32'd95,         32'h8000_0000, 32'h0,         32'h0,         32'h0},         // R3 highest
        '{13'h040, 32'd96,         32'h0,         32'h0,         32'h0,         32'h0},         // R6 above
        '{13'h040, 32'd63,         32'h0,         32'h0,         32'h8000_0000, 32'h0},         // R6 below, R4
        '{13'h040, 32'd0,          32'h0,         32'h0000_0001, 32'h0,         32'h0},         // R4 base-offset
        '{13'h040, 32'd31,         32'h0,         32'h8000_0000, 32'h0,         32'h0},         // R4
        '{13'h040, 32'd32,         32'h0,         32'h0,         32'h0000_0001, 32'h0},         // R4 offset-32
        '{13'h040, 32'hFFFF_FFFF,  32'h0,         32'h0,         32'h0,         32'h0},         // R4 no wrap
        '{13'h040, 32'd20,         32'h0,         32'h0010_0000, 32'h0,         32'h0},         // R7 bad stays low
        '{13'h100, 32'h0000_DEAD,  32'h0,         32'h0,         32'h0,         32'h0000_0001}, // R5
        '{13'h1F8, 32'h0,          32'h0,         32'h0,         32'h0,         32'h8000_0000}, // R5
        '{13'h200, 32'h0,          32'h0,         32'h0,         32'h0,         32'h0},         // R5/R6
        '{13'h0F8, 32'h0,          32'h0,         32'h0,         32'h0,         32'h0},         // R5/R6
        '{13'h104, 32'h0,          32'h0,         32'h0,         32'h0,         32'h0},         // R5 misaligned
        '{13'h008, 32'd64,         32'h0,         32'h0,         32'h0,         32'h0},         // R8
        '{13'h044, 32'd64,         32'h0,         32'h0,         32'h0,         32'h0},         // R8
        '{13'h180, 32'd5,          32'h0,         32'h0,         32'h0,         32'h0001_0000}  // R5 mid
    };

    task automatic check32(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Issue one write; returns at the next falling edge with the pulse visible
    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Issue one read; returns with rdata of all instances valid
    task automatic bus_read(input logic [AW-1:0] a);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
            finish_run();
        end
    end

    initial begin
        // R10: a doorbell and a read presented during reset must not leak out
        wr_en = 1'b1; addr = 13'h040; wdata = 32'd64; rd_en = 1'b1;
        repeat (3) @(negedge clk);
        check32("R10", "pulse in reset", p_abs | p_ao | p_ob | p_o32, 32'h0);
        check32("R10", "rdata in reset", rd_abs, 32'h0);
        wr_en = 1'b0; rd_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check32("R10", "pulse after reset", p_abs, 32'h0);

        // Vector table: R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            bus_write(VECS[i].a, VECS[i].d);
            check32("R3", $sformatf("abs vec %0d", i), p_abs, VECS[i].e_abs);
            check32("R4", $sformatf("sub-base vec %0d", i), p_ob, VECS[i].e_ob);
            check32("R4", $sformatf("sub-32 vec %0d", i), p_o32, VECS[i].e_o32);
            check32("R5", $sformatf("addr-enc vec %0d", i), p_ao, VECS[i].e_ao);
            check32("R7", $sformatf("invalid range vec %0d", i), p_bad, 32'h0);
            @(negedge clk);
            check32("R3", $sformatf("one-cycle width vec %0d", i),
                    p_abs | p_ob | p_o32 | p_ao, 32'h0);
        end

        // R1: type word layout
        bus_read(13'h008);
        check32("R1", "type word", rd_abs, 32'h0040_0020);
        check32("R1", "type word bad range", rd_bad, 32'h0010_0020);
        check32("R5", "type in addr mode", rd_ao, 32'h0);
        @(negedge clk);
        check32("R2", "rdata idle", rd_abs, 32'h0);

        // R2: identification and unmapped offsets
        bus_read(13'h0FCC);
        check32("R2", "ident", rd_abs, ID);
        check32("R5", "ident in addr mode", rd_ao, 32'h0);
        bus_read(13'h010);
        check32("R2", "unmapped read", rd_abs, 32'h0);
        bus_read(13'h040);
        check32("R2", "doorbell read", rd_abs, 32'h0);

        // R8: a write to the type offset leaves it unchanged
        bus_write(13'h008, 32'hFFFF_FFFF);
        check32("R8", "no pulse on type write", p_abs, 32'h0);
        bus_read(13'h008);
        check32("R8", "type after write", rd_abs, 32'h0040_0020);

        // Write and read in the same cycle (R3, R1)
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b1; addr = 13'h040; wdata = 32'd80;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check32("R3", "pulse with overlapping read", p_abs, 32'h0001_0000);
        check32("R2", "rdata of doorbell offset during write", rd_abs, 32'h0);
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b1; addr = 13'h008; wdata = 32'd70;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check32("R1", "type read alongside write", rd_abs, 32'h0040_0020);
        check32("R8", "no pulse from type write", p_abs, 32'h0);

        // R9: back-to-back doorbells to different SPIs
        @(negedge clk);
        wr_en = 1'b1; addr = 13'h040; wdata = 32'd64;
        @(negedge clk);
        wdata = 32'd70;
        check32("R9", "first pulse", p_abs, 32'h0000_0001);
        @(negedge clk);
        wr_en = 1'b0;
        check32("R9", "second pulse", p_abs, 32'h0000_0040);
        @(negedge clk);
        check32("R9", "quiet after pair", p_abs, 32'h0);

        finish_run();
    end

endmodule